// File: doc/BRIEF.md
# Programmable-Length Serial Frame Shifter

This block moves one byte at a time over a clock line and a data line. An internal divider produces the serial clock. It supports two framing formats. In the two-wire bus format, every frame ends with one acknowledge bit after the data bits. In the clock-synchronous format, a frame carries data bits only. A 3-bit count code sets the frame length, and the same code maps to a different length in each format. While a frame runs, the count field reads back the bits still to go. At the end of every frame it returns to zero, so the next frame defaults to full length.

The transmit side has a one-byte holding buffer and a transmit-empty flag. The flag sets when the buffer is copied into the shift register and clears when a new byte is written. A maskable interrupt output is raised from that flag. During a transmit the block captures the acknowledge bit that comes back. During a receive it drives an acknowledge value chosen by software. Bits are shifted most significant first. The data line changes only while the clock is low, and input is sampled when the clock rises.

Top module: `frame_shifter`

## Requirements
- R1: In bus format (`cfg_bus_fmt`=1), count code 000 gives a 9-clock frame and code c (1..7) gives c+1 clocks. The final clock of each frame is the acknowledge bit.
- R2: In synchronous format (`cfg_bus_fmt`=0), count code 000 gives an 8-clock frame and code c (1..7) gives c clocks, with no acknowledge bit.
- R3: While `busy` is 1, `cnt_rd` equals the number of bits not yet completed in the frame (including the current one), modulo 8. While idle, it shows the stored count code.
- R4: The stored count code returns to 000 on its own when a frame completes. In bus format that happens only after the acknowledge clock.
- R5: A count write while idle in bus format is accepted if the value is 000 or if `scl_out` is low. Writes while busy, writes of a nonzero value while `scl_out` is high, and writes in the same cycle as `start` are ignored.
- R6: In synchronous format every count write is ignored.
- R7: `tdre` resets to 0, sets when a transmit frame starts, and clears on `data_wr`. `tx_irq` is 1 exactly when both `tdre` and `tx_ie` are 1.
- R8: Data goes out and comes in most significant bit first. `sda_out` changes only while `scl_out` is low. `sda_in` is sampled when `scl_out` rises. After a receive frame of D data bits, `rx_data[D-1:0]` holds them with the first received bit in bit D-1.
- R9: In bus format, a transmit frame captures `sda_in` at the acknowledge clock into `ack_rcvd`. A receive frame drives `ack_drive` on `sda_out` during the acknowledge clock. During a transmit acknowledge clock, and whenever the block is idle, `sda_out` is 1 (released).
- R10: After reset `scl_out` and `sda_out` are 1, and `busy`, `cnt_rd`, `tdre`, `tx_irq` and `ack_rcvd` are 0. After any completed frame `scl_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bus_fmt | input | 1 | 1 = bus format with acknowledge, 0 = synchronous format |
| cfg_tx | input | 1 | 1 = transmit frame, 0 = receive frame (latched at start) |
| start | input | 1 | Begin a frame when idle |
| cnt_wr | input | 1 | Write strobe for the count code |
| cnt_wdata | input | CNT_W | Count code to write |
| data_wr | input | 1 | Write strobe for the transmit buffer |
| data_wdata | input | DATA_W | Transmit byte |
| tx_ie | input | 1 | Transmit interrupt enable |
| ack_drive | input | 1 | Acknowledge value driven on receive frames |
| sda_in | input | 1 | Data line as seen on the wire |
| scl_out | output | 1 | Serial clock |
| sda_out | output | 1 | Data line drive, 1 = released |
| busy | output | 1 | Frame in progress |
| cnt_rd | output | CNT_W | Bits remaining while busy, count code while idle |
| rx_data | output | DATA_W | Shift register contents, received bits in the low positions |
| tdre | output | 1 | Transmit buffer empty flag |
| tx_irq | output | 1 | Transmit interrupt request |
| ack_rcvd | output | 1 | Acknowledge bit captured on the last transmit frame |

## Verification
The hardest case to reach is a nonzero count write that is accepted. This requires the block to be idle in bus format with the clock already low. That state only exists after a frame has completed, because reset leaves the clock high. The stimulus therefore first attempts a nonzero write straight after reset and expects it to be refused. It then runs a full frame, writes the code while the line rests low, and switches to the synchronous format before the next start. This proves that a code set under one format is honoured as a length under the other. A write is also issued in the middle of a running frame, and the count read afterwards must be zero.

// File: rtl/fs_pkg.sv
package fs_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_e;
endpackage

// File: rtl/fs_phase_timer.sv
module fs_phase_timer #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [DW-1:0] tick;

   assign done = run && (tick == DW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              tick <= '0;
      else if (!run || done)   tick <= '0;
      else                     tick <= tick + 1'b1;
   end
endmodule

// File: rtl/fs_len_counter.sv
module fs_len_counter #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fmt_bus,
   input  logic             idle,
   input  logic             scl_low,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             load,
   input  logic             step,
   output logic             rem_one,
   output logic             rem_two,
   output logic [CNT_W-1:0] cnt_rd
);
   localparam int REM_W = CNT_W + 1;
   localparam int FULL  = 1 << CNT_W;

   logic [CNT_W-1:0] code_q;
   logic [REM_W-1:0] rem_q;
   logic [REM_W-1:0] len;
   logic             wr_ok;

   always_comb begin
      if (fmt_bus) len = (code_q == '0) ? REM_W'(FULL + 1) : REM_W'(code_q) + 1'b1;
      else         len = (code_q == '0) ? REM_W'(FULL)     : REM_W'(code_q);
   end

   assign wr_ok   = wr && idle && !load && fmt_bus && ((wdata == '0) || scl_low);
   assign rem_one = (rem_q == REM_W'(1));
   assign rem_two = (rem_q == REM_W'(2));
   assign cnt_rd  = idle ? code_q : rem_q[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         rem_q  <= '0;
      end else begin
         if (load)               rem_q <= len;
         else if (step)          rem_q <= rem_q - 1'b1;
         if (step && rem_one)    code_q <= '0;
         else if (wr_ok)         code_q <= wdata;
      end
   end
endmodule

// File: rtl/fs_shifter.sv
module fs_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              load,
   input  logic              tx_mode,
   input  logic              shift,
   input  logic              sin,
   output logic              buf_msb,
   output logic              sh_msb,
   output logic              tdre,
   output logic [DATA_W-1:0] sh_q
);
   logic [DATA_W-1:0] hold_q;

   assign buf_msb = hold_q[DATA_W-1];
   assign sh_msb  = sh_q[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         sh_q   <= '0;
         tdre   <= 1'b0;
      end else begin
         if (wr) hold_q <= wdata;
         if (load)       sh_q <= hold_q;
         else if (shift) sh_q <= {sh_q[DATA_W-2:0], sin};
         if (wr)                   tdre <= 1'b0;
         else if (load && tx_mode) tdre <= 1'b1;
      end
   end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 3,
   parameter int HALF_PERIOD = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bus_fmt,
   input  logic              cfg_tx,
   input  logic              start,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_wdata,
   input  logic              tx_ie,
   input  logic              ack_drive,
   input  logic              sda_in,
   output logic              scl_out,
   output logic              sda_out,
   output logic              busy,
   output logic [CNT_W-1:0]  cnt_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              tdre,
   output logic              tx_irq,
   output logic              ack_rcvd
);
   import fs_pkg::*;

   if (DATA_W != (1 << CNT_W)) begin : g_bad_width
      $error("frame_shifter: DATA_W must equal 2**CNT_W");
   end
   if (HALF_PERIOD < 2) begin : g_bad_half
      $error("frame_shifter: HALF_PERIOD must be at least 2");
   end

   phase_e ph_q;
   logic   scl_q, sda_q, fmt_q, tx_q, ack_q;
   logic   idle, go, half_done, lo_done, hi_done;
   logic   rem_one, rem_two, on_ack, nxt_ack, shift;
   logic   buf_msb, sh_msb;

   assign idle    = (ph_q == PH_IDLE);
   assign go      = start && idle;
   assign lo_done = (ph_q == PH_LOW)  && half_done;
   assign hi_done = (ph_q == PH_HIGH) && half_done;
   assign on_ack  = fmt_q && rem_one;
   assign nxt_ack = fmt_q && rem_two;
   assign shift   = lo_done && !on_ack;

   fs_phase_timer #(.HALF(HALF_PERIOD)) timer_i (
      .clk(clk), .rst_n(rst_n), .run(!idle), .done(half_done)
   );

   fs_len_counter #(.CNT_W(CNT_W)) len_i (
      .clk(clk), .rst_n(rst_n), .fmt_bus(cfg_bus_fmt), .idle(idle),
      .scl_low(!scl_q), .wr(cnt_wr), .wdata(cnt_wdata), .load(go),
      .step(hi_done), .rem_one(rem_one), .rem_two(rem_two), .cnt_rd(cnt_rd)
   );

   fs_shifter #(.DATA_W(DATA_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .wr(data_wr), .wdata(data_wdata),
      .load(go), .tx_mode(cfg_tx), .shift(shift), .sin(sda_in),
      .buf_msb(buf_msb), .sh_msb(sh_msb), .tdre(tdre), .sh_q(rx_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         scl_q <= 1'b1;
         sda_q <= 1'b1;
         fmt_q <= 1'b0;
         tx_q  <= 1'b0;
         ack_q <= 1'b0;
      end else begin
         case (ph_q)
            PH_IDLE: if (go) begin
               ph_q  <= PH_LOW;
               fmt_q <= cfg_bus_fmt;
               tx_q  <= cfg_tx;
               scl_q <= 1'b0;
               sda_q <= cfg_tx ? buf_msb : 1'b1;
            end
            PH_LOW: if (lo_done) begin
               ph_q  <= PH_HIGH;
               scl_q <= 1'b1;
               if (on_ack && tx_q) ack_q <= sda_in;
            end
            PH_HIGH: if (hi_done) begin
               scl_q <= 1'b0;
               if (rem_one) begin
                  ph_q  <= PH_IDLE;
                  sda_q <= 1'b1;
               end else begin
                  ph_q <= PH_LOW;
                  if (nxt_ack) sda_q <= tx_q ? 1'b1 : ack_drive;
                  else         sda_q <= tx_q ? sh_msb : 1'b1;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign scl_out  = scl_q;
   assign sda_out  = sda_q;
   assign busy     = !idle;
   assign ack_rcvd = ack_q;
   assign tx_irq   = tdre && tx_ie;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_bus_fmt,
   input logic             start,
   input logic             cnt_wr,
   input logic             data_wr,
   input logic             scl_out,
   input logic             sda_out,
   input logic             busy,
   input logic [CNT_W-1:0] cnt_rd,
   input logic             tx_irq
);
   a_r8_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_out && $past(scl_out)) |-> $stable(sda_out));

   a_r4_code_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (cnt_rd == '0));

   a_r6_sync_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cfg_bus_fmt && cnt_wr && !start) |=> $stable(cnt_rd));

   a_r7_write_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !tx_irq);

   a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sda_out);
endmodule

bind frame_shifter fs_checker #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cfg_bus_fmt(cfg_bus_fmt), .start(start),
   .cnt_wr(cnt_wr), .data_wr(data_wr), .scl_out(scl_out), .sda_out(sda_out),
   .busy(busy), .cnt_rd(cnt_rd), .tx_irq(tx_irq)
);

// File: tb/frame_shifter_tb.sv
module frame_shifter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 2;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_bus_fmt = 1'b1, cfg_tx = 1'b1, start = 1'b0;
   logic       cnt_wr = 1'b0, data_wr = 1'b0, tx_ie = 1'b0, ack_drive = 1'b0;
   logic [2:0] cnt_wdata = '0;
   logic [7:0] data_wdata = '0;
   logic       sda_in, scl_out, sda_out, busy, tdre, tx_irq, ack_rcvd;
   logic [2:0] cnt_rd;
   logic [7:0] rx_data;
   logic [15:0] pat = 16'hB38E;

   int vec_cnt = 0, miss_cnt = 0, cyc = 0, pulses = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_in = sda_out & pat[15];
   always @(negedge scl_out) pat <= {pat[14:0], pat[15]};
   always @(posedge scl_out) pulses++;

   frame_shifter #(.DATA_W(8), .CNT_W(3), .HALF_PERIOD(HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_bus_fmt(cfg_bus_fmt), .cfg_tx(cfg_tx),
      .start(start), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .data_wr(data_wr),
      .data_wdata(data_wdata), .tx_ie(tx_ie), .ack_drive(ack_drive),
      .sda_in(sda_in), .scl_out(scl_out), .sda_out(sda_out), .busy(busy),
      .cnt_rd(cnt_rd), .rx_data(rx_data), .tdre(tdre), .tx_irq(tx_irq),
      .ack_rcvd(ack_rcvd)
   );

   // behavioural reference model
   int m_ph = 0, m_div = 0, m_len = 0, m_k = 0, m_code = 0;
   int m_rxv = 0, m_dbits = 0;
   bit m_scl = 1, m_sda = 1, m_fmt = 0, m_tx = 0, m_ack = 0, m_tdre = 0;
   bit m_rx_ok = 0, m_live = 0;
   logic [7:0] m_buf = '0, m_loaded = '0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_ph = 0; m_div = 0; m_code = 0; m_scl = 1; m_sda = 1;
         m_ack = 0; m_tdre = 0; m_buf = '0; m_rx_ok = 0; m_live = 1;
      end else begin
         case (m_ph)
            0: begin
               if (start) begin
                  m_ph = 1; m_div = 0; m_fmt = cfg_bus_fmt; m_tx = cfg_tx;
                  if (m_fmt) m_len = (m_code == 0) ? 9 : m_code + 1;
                  else       m_len = (m_code == 0) ? 8 : m_code;
                  m_dbits = m_fmt ? m_len - 1 : m_len;
                  m_k = 0; m_rxv = 0; m_rx_ok = 0; m_loaded = m_buf;
                  if (m_tx) m_tdre = 1;
                  m_scl = 0; m_sda = m_tx ? m_buf[7] : 1'b1;
               end else if (cnt_wr && cfg_bus_fmt && (cnt_wdata == 0 || !m_scl))
                  m_code = int'(cnt_wdata);
            end
            1: if (m_div == HALF-1) begin
               m_div = 0; m_ph = 2; m_scl = 1;
               if (m_fmt && m_k == m_len-1) begin
                  if (m_tx) m_ack = sda_in;
               end else m_rxv = m_rxv * 2 + int'(sda_in);
            end else m_div++;
            default: if (m_div == HALF-1) begin
               m_div = 0; m_k++; m_scl = 0;
               if (m_k == m_len) begin
                  m_ph = 0; m_sda = 1; m_code = 0; m_rx_ok = !m_tx;
               end else begin
                  m_ph = 1;
                  if (m_fmt && m_k == m_len-1) m_sda = m_tx ? 1'b1 : ack_drive;
                  else                         m_sda = m_tx ? m_loaded[7-m_k] : 1'b1;
               end
            end else m_div++;
         endcase
         if (data_wr) begin m_buf = data_wdata; m_tdre = 0; end
      end
   end

   function automatic void chk(string tag, int got, int exp);
      vec_cnt++;
      if (got != exp) begin
         miss_cnt++;
         $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cyc);
      end
   endfunction

   always @(negedge clk) if (m_live && !done_flag) begin
      chk("R8 scl_out", int'(scl_out), int'(m_scl));
      chk("R8 sda_out", int'(sda_out), int'(m_sda));
      chk("R1 busy", int'(busy), int'(m_ph != 0));
      chk("R3 cnt_rd", int'(cnt_rd), (m_ph != 0) ? ((m_len - m_k) % 8) : m_code);
      chk("R7 tdre", int'(tdre), int'(m_tdre));
      chk("R7 tx_irq", int'(tx_irq), int'(m_tdre && tx_ie));
      chk("R9 ack_rcvd", int'(ack_rcvd), int'(m_ack));
      if (m_rx_ok)
         chk("R8 rx_data", int'(rx_data) & ((1 << m_dbits) - 1), m_rxv);
   end

   task automatic finish_run();
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
      $finish;
   endtask

   always @(posedge clk) if (cyc > WATCHDOG && !done_flag) begin
      vec_cnt++; miss_cnt++;
      $display("FAIL watchdog: got %0d expected below %0d", cyc, WATCHDOG);
      finish_run();
   end

   task automatic wr_cnt(input logic [2:0] v);
      @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
      @(negedge clk); cnt_wr = 1'b0;
   endtask

   task automatic wr_data(input logic [7:0] v);
      @(negedge clk); data_wr = 1'b1; data_wdata = v;
      @(negedge clk); data_wr = 1'b0;
   endtask

   task automatic frame(input bit bus, input bit tx, input bit midwr,
                        input int exp_pulses, input string tag);
      @(negedge clk); cfg_bus_fmt = bus; cfg_tx = tx; pulses = 0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (midwr) wr_cnt(3'd5);
      while (busy) @(negedge clk);
      chk(tag, pulses, exp_pulses);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset values
      chk("R10 scl", int'(scl_out), 1);
      chk("R10 sda", int'(sda_out), 1);
      chk("R10 flags", int'({busy, tdre, tx_irq, ack_rcvd}), 0);
      chk("R10 cnt", int'(cnt_rd), 0);
      rst_n = 1'b1;
      // R5: nonzero write refused while scl is high after reset
      wr_cnt(3'd3);
      chk("R5 write with scl high", int'(cnt_rd), 0);
      tx_ie = 1'b1;
      wr_data(8'hA5);
      chk("R7 tdre cleared by write", int'(tdre), 0);
      // R1: default bus transmit frame, 9 clocks with acknowledge
      frame(1, 1, 0, 9, "R1 bus code 000 pulses");
      chk("R7 irq after tx start", int'(tx_irq), 1);
      chk("R10 scl low after frame", int'(scl_out), 0);
      // R5: nonzero write accepted once scl rests low
      wr_cnt(3'd3);
      chk("R5 write with scl low", int'(cnt_rd), 3);
      ack_drive = 1'b0;
      frame(1, 0, 0, 4, "R1 bus code 011 pulses");
      chk("R4 code back to 000", int'(cnt_rd), 0);
      // R5: write while busy ignored
      wr_data(8'h3C);
      frame(1, 1, 1, 9, "R5 busy write frame pulses");
      chk("R5 busy write ignored", int'(cnt_rd), 0);
      // R6: synchronous format ignores writes, code 000 gives 8 clocks
      cfg_bus_fmt = 1'b0;
      wr_cnt(3'd2);
      chk("R6 sync write ignored", int'(cnt_rd), 0);
      frame(0, 0, 0, 8, "R2 sync code 000 pulses");
      // R2: code set in bus format honoured in sync format
      cfg_bus_fmt = 1'b1;
      wr_cnt(3'd4);
      chk("R5 code 100 stored", int'(cnt_rd), 4);
      tx_ie = 1'b0;
      wr_data(8'h96);
      frame(0, 1, 0, 4, "R2 sync code 100 pulses");
      chk("R7 irq masked", int'(tx_irq), 0);
      // R9: receive with acknowledge driven high, code 111
      cfg_bus_fmt = 1'b1;
      wr_cnt(3'd7);
      ack_drive = 1'b1;
      frame(1, 0, 0, 8, "R9 bus code 111 rx pulses");
      wr_cnt(3'd1);
      frame(1, 1, 0, 2, "R1 bus code 001 pulses");
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule